// File: doc/BRIEF.md
# Machine Cycle Sequencer

This block decides which machine cycle of the current instruction is active: the opcode fetch cycle, the first or second read cycle, or the first or second write cycle. It works on a single clock in which every edge stands for one half of a two-phase state. A phase input tells the block whether the edge it sees opens the first or the second half. Control inputs are sampled on first-half edges. Cycle changes become visible on the following second-half edge.

The surrounding control logic supplies the active T-state strobes (T3, T4, T6) and a flag that stretches the fetch cycle to six states. It also supplies, for each instruction, two skip flags, a 3-bit code naming the final cycle, and strobes that report a failed branch condition. From these the sequencer steps through the cycles in their fixed order. It raises a next-instruction pulse when the instruction is complete and then returns to the fetch cycle.

Top module: `mcyc_sequencer`

## Requirements
- R1: `cyc_flags` is always exactly one-hot, with bit 0 = fetch (M1), bit 1 = read 1 (R1), bit 2 = read 2 (R2), bit 3 = write 1 (W1) and bit 4 = write 2 (W2).
- R2: When a cycle ends without ending the instruction, the next cycle follows the order M1, R1, R2, W1, W2.
- R3: When a fetch cycle ends with `skip_r2` high, the next cycle is R2. When it ends with `skip_w1` high, the next cycle is W1. The two flags are never high together.
- R4: A read or write cycle ends on the state where `st_t3` is high. A fetch cycle ends on `st_t4` when `long_m1` is low, and on `st_t6` when `long_m1` is high.
- R5: The instruction ends, with `next_instr` raised and the fetch cycle following, when the ending cycle matches `last_code`. The codes are 3'b111 = M1, 3'b100 = R1, 3'b101 = R2, 3'b110 = W1 and 3'b011 = W2.
- R6: `ret_fail` high at fetch T6 ends the instruction there. `jc_fail` high at R1 T3 ends the instruction there, whatever `last_code` says.
- R7: Inputs are sampled only on edges where `ph2` is 0, and `next_instr` changes only on those edges. `cyc_flags` changes only on edges where `ph2` is 1, one edge after the end was sampled.
- R8: When single-cycle instructions follow each other, the M1 bit stays high on every edge between them, while `next_instr` pulses at each instruction end.
- R9: Synchronous reset `rst` forces the fetch cycle on the next edge in any cycle, and clears `next_instr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock |
| rst | input | 1 | Synchronous active-high reset |
| ph2 | input | 1 | 0 = edge opens first half, 1 = edge opens second half |
| st_t3 | input | 1 | Current state is T3 |
| st_t4 | input | 1 | Current state is T4 |
| st_t6 | input | 1 | Current state is T6 |
| long_m1 | input | 1 | Fetch cycle lasts six states |
| skip_r2 | input | 1 | Fetch goes straight to R2 |
| skip_w1 | input | 1 | Fetch goes straight to W1 |
| last_code | input | 3 | Code of the instruction's final cycle |
| ret_fail | input | 1 | Conditional return failed its test |
| jc_fail | input | 1 | Conditional jump or call failed its test |
| cyc_flags | output | 5 | One-hot active cycle |
| next_instr | output | 1 | Current instruction is complete |

## Verification
The hardest situation to reach is an instruction that ends early on a failed condition at exactly the right state: fetch T6 of a stretched fetch, or R1 T3. The `last_code` given in that case would let the instruction continue. To get there, the bench walks the T-state strobes state by state with the phase input alternating. It checks after both edges of every state that the cycle holds through the middle of a cycle and changes only on the second-half edge after the end. Reset is also applied in the middle of a five-cycle instruction to show that it returns at once to fetch.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
    localparam int NUM_CYC = 5;
    localparam int CODE_W  = 3;
    localparam int CYC_W   = $clog2(NUM_CYC);

    typedef enum logic [CYC_W-1:0] {
        CY_M1 = 3'd0,
        CY_R1 = 3'd1,
        CY_R2 = 3'd2,
        CY_W1 = 3'd3,
        CY_W2 = 3'd4
    } cyc_e;

    typedef struct packed {
        logic t3;
        logic t4;
        logic t6;
    } tstate_t;

    typedef struct packed {
        logic              long_m1;
        logic              skip_r2;
        logic              skip_w1;
        logic [CODE_W-1:0] last_code;
        logic              ret_fail;
        logic              jc_fail;
    } instr_ctl_t;

    // True when cycle c is the final cycle named by the code
    function automatic logic is_last(input cyc_e c, input logic [CODE_W-1:0] code);
        case (code)
            3'b111:  return c == CY_M1;
            3'b100:  return c == CY_R1;
            3'b101:  return c == CY_R2;
            3'b110:  return c == CY_W1;
            3'b011:  return c == CY_W2;
            default: return 1'b0;
        endcase
    endfunction

    // Cycle that follows c inside the same instruction
    function automatic cyc_e successor(input cyc_e c, input logic sr2, input logic sw1);
        case (c)
            CY_M1:   return sr2 ? CY_R2 : (sw1 ? CY_W1 : CY_R1);
            CY_R1:   return CY_R2;
            CY_R2:   return CY_W1;
            CY_W1:   return CY_W2;
            default: return CY_M1;
        endcase
    endfunction
endpackage

// File: rtl/mcs_end_detect.sv
`timescale 1ns/1ps
module mcs_end_detect
    import mcs_pkg::*;
(
    input  cyc_e       cur,
    input  tstate_t    ts,
    input  instr_ctl_t ctl,
    output logic       end_c,
    output logic       next_c,
    output cyc_e       succ_c
);
    logic is_m1;
    logic early;

    always_comb begin
        is_m1  = (cur == CY_M1);
        end_c  = is_m1 ? ((ts.t4 & ~ctl.long_m1) | ts.t6) : ts.t3;
        early  = (is_m1 & ts.t6 & ctl.ret_fail)
               | ((cur == CY_R1) & ts.t3 & ctl.jc_fail);
        next_c = end_c & (early | is_last(cur, ctl.last_code));
        succ_c = successor(cur, ctl.skip_r2, ctl.skip_w1);
    end
endmodule

// File: rtl/mcs_sample_reg.sv
`timescale 1ns/1ps
module mcs_sample_reg
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph2,
    input  logic end_c,
    input  logic next_c,
    input  cyc_e succ_c,
    output logic end_q,
    output logic next_q,
    output cyc_e succ_q
);
    // First-half edges capture the end decision and the following cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            end_q  <= 1'b0;
            next_q <= 1'b0;
            succ_q <= CY_M1;
        end else if (!ph2) begin
            end_q  <= end_c;
            next_q <= next_c;
            succ_q <= succ_c;
        end
    end
endmodule

// File: rtl/mcs_cycle_reg.sv
`timescale 1ns/1ps
module mcs_cycle_reg
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph2,
    input  logic end_q,
    input  logic next_q,
    input  cyc_e succ_q,
    output cyc_e cur
);
    // Second-half edges apply the decision captured one edge earlier
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= CY_M1;
        end else if (ph2 && end_q) begin
            cur <= next_q ? CY_M1 : succ_q;
        end
    end
endmodule

// File: rtl/mcyc_sequencer.sv
`timescale 1ns/1ps
module mcyc_sequencer
    import mcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ph2,
    input  logic               st_t3,
    input  logic               st_t4,
    input  logic               st_t6,
    input  logic               long_m1,
    input  logic               skip_r2,
    input  logic               skip_w1,
    input  logic [CODE_W-1:0]  last_code,
    input  logic               ret_fail,
    input  logic               jc_fail,
    output logic [NUM_CYC-1:0] cyc_flags,
    output logic               next_instr
);
    tstate_t    ts;
    instr_ctl_t ctl;
    cyc_e       cur, succ_c, succ_q;
    logic       end_c, next_c, end_q, next_q;

    assign ts  = '{t3: st_t3, t4: st_t4, t6: st_t6};
    assign ctl = '{long_m1: long_m1, skip_r2: skip_r2, skip_w1: skip_w1,
                   last_code: last_code, ret_fail: ret_fail, jc_fail: jc_fail};

    mcs_end_detect u_end (
        .cur(cur), .ts(ts), .ctl(ctl),
        .end_c(end_c), .next_c(next_c), .succ_c(succ_c)
    );

    mcs_sample_reg u_smp (
        .clk(clk), .rst(rst), .ph2(ph2),
        .end_c(end_c), .next_c(next_c), .succ_c(succ_c),
        .end_q(end_q), .next_q(next_q), .succ_q(succ_q)
    );

    mcs_cycle_reg u_cyc (
        .clk(clk), .rst(rst), .ph2(ph2),
        .end_q(end_q), .next_q(next_q), .succ_q(succ_q),
        .cur(cur)
    );

    // R1: one flag bit per cycle, decoded from the encoded state
    for (genvar i = 0; i < NUM_CYC; i++) begin : g_flag
        assign cyc_flags[i] = (cur == cyc_e'(CYC_W'(i)));
    end

    assign next_instr = next_q;
endmodule

// File: rtl/mcs_checker.sv
`timescale 1ns/1ps
module mcs_checker
    import mcs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ph2,
    input logic [NUM_CYC-1:0] cyc_flags,
    input logic               next_instr
);
    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(cyc_flags) == 1);

    assert_flags_second_half_R7: assert property (@(posedge clk) disable iff (rst)
        (!ph2) |=> $stable(cyc_flags));

    assert_next_first_half_R7: assert property (@(posedge clk) disable iff (rst)
        (ph2) |=> $stable(next_instr));

    assert_next_to_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        (ph2 && next_instr) |=> cyc_flags[0]);

    assert_reset_fetch_R9: assert property (@(posedge clk)
        rst |=> (cyc_flags == 5'b00001 && !next_instr));
endmodule

bind mcyc_sequencer mcs_checker u_chk (
    .clk(clk), .rst(rst), .ph2(ph2),
    .cyc_flags(cyc_flags), .next_instr(next_instr)
);

// File: tb/sim_mcyc_sequencer.sv
`timescale 1ns/1ps
module sim_mcyc_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ph2 = 1'b0;
    logic       st_t3 = 0, st_t4 = 0, st_t6 = 0;
    logic       long_m1 = 0, skip_r2 = 0, skip_w1 = 0;
    logic [2:0] last_code = 3'b111;
    logic       ret_fail = 0, jc_fail = 0;
    logic [4:0] cyc_flags;
    logic       next_instr;

    int checks = 0;
    int failures = 0;

    localparam int M1 = 0, R1 = 1, R2 = 2, W1 = 3, W2 = 4;

    mcyc_sequencer u0 (
        .clk(clk), .rst(rst), .ph2(ph2),
        .st_t3(st_t3), .st_t4(st_t4), .st_t6(st_t6),
        .long_m1(long_m1), .skip_r2(skip_r2), .skip_w1(skip_w1),
        .last_code(last_code), .ret_fail(ret_fail), .jc_fail(jc_fail),
        .cyc_flags(cyc_flags), .next_instr(next_instr)
    );

    always #2 clk = ~clk;
    always @(negedge clk) ph2 <= rst ? 1'b0 : ~ph2;

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_instr(input logic [2:0] code, input bit lng, input bit sr2,
                             input bit sw1, input bit rf, input bit jf);
        last_code = code; long_m1 = lng; skip_r2 = sr2; skip_w1 = sw1;
        ret_fail = rf; jc_fail = jf;
    endtask

    // Walks one cycle of nst states; exp = active cycle, nxt = cycle after it
    task automatic do_cycle(input int exp, input int nst, input int nxt,
                            input bit exp_next, input string req);
        for (int s = 1; s <= nst; s++) begin
            do begin @(negedge clk); #1; end while (ph2 != 1'b0);
            st_t3 = (s == 3); st_t4 = (s == 4); st_t6 = (s == 6);
            @(posedge clk); #1;
            chk(cyc_flags == (5'b1 << exp), {req, " R7 flags held at first-half edge"},
                cyc_flags, 5'b1 << exp);
            if (s == nst)
                chk(next_instr == exp_next, {req, " R7 next_instr at first-half edge"},
                    next_instr, exp_next);
            @(posedge clk); #1;
            if (s < nst)
                chk(cyc_flags == (5'b1 << exp), {req, " cycle held mid-cycle"},
                    cyc_flags, 5'b1 << exp);
            else begin
                chk(cyc_flags == (5'b1 << nxt), {req, " next cycle"}, cyc_flags, 5'b1 << nxt);
                chk(next_instr == exp_next, {req, " next_instr held"}, next_instr, exp_next);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; st_t3 = 0; st_t4 = 0; st_t6 = 0;
        @(posedge clk); #1;
        chk(cyc_flags == 5'b00001, "R9 reset forces M1", cyc_flags, 5'b00001);
        chk(next_instr == 1'b0, "R9 reset clears next_instr", next_instr, 0);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic t_single_back_to_back();
        set_instr(3'b111, 0, 0, 0, 0, 0);
        do_cycle(M1, 4, M1, 1, "R8 R5 single-cycle 1st");
        do_cycle(M1, 4, M1, 1, "R8 R5 single-cycle 2nd");
    endtask

    task automatic t_two_cycle();
        set_instr(3'b100, 0, 0, 0, 0, 0);
        do_cycle(M1, 4, R1, 0, "R2 R4 two-cycle fetch");
        do_cycle(R1, 3, M1, 1, "R5 two-cycle last R1");
    endtask

    task automatic t_three_cycle();
        set_instr(3'b101, 0, 0, 0, 0, 0);
        do_cycle(M1, 4, R1, 0, "R2 three-cycle fetch");
        do_cycle(R1, 3, R2, 0, "R2 three-cycle R1");
        do_cycle(R2, 3, M1, 1, "R5 three-cycle last R2");
    endtask

    task automatic t_five_cycle();
        set_instr(3'b011, 0, 0, 0, 0, 0);
        do_cycle(M1, 4, R1, 0, "R2 five-cycle fetch");
        do_cycle(R1, 3, R2, 0, "R2 five-cycle R1");
        do_cycle(R2, 3, W1, 0, "R2 five-cycle R2");
        do_cycle(W1, 3, W2, 0, "R2 five-cycle W1");
        do_cycle(W2, 3, M1, 1, "R5 five-cycle last W2");
    endtask

    task automatic t_skip_r2();
        set_instr(3'b110, 0, 1, 0, 0, 0);
        do_cycle(M1, 4, R2, 0, "R3 skip to R2");
        do_cycle(R2, 3, W1, 0, "R3 R2 then W1");
        do_cycle(W1, 3, M1, 1, "R5 last W1");
    endtask

    task automatic t_skip_w1();
        set_instr(3'b011, 0, 0, 1, 0, 0);
        do_cycle(M1, 4, W1, 0, "R3 skip to W1");
        do_cycle(W1, 3, W2, 0, "R3 W1 then W2");
        do_cycle(W2, 3, M1, 1, "R5 last W2 after skip");
    endtask

    task automatic t_long_fetch();
        set_instr(3'b111, 1, 0, 0, 0, 0);
        do_cycle(M1, 6, M1, 1, "R4 long fetch ends at T6");
        set_instr(3'b100, 1, 0, 0, 0, 0);
        do_cycle(M1, 6, R1, 0, "R4 long fetch then R1");
        do_cycle(R1, 3, M1, 1, "R5 long fetch instr last R1");
    endtask

    task automatic t_ret_fail();
        set_instr(3'b100, 1, 0, 0, 1, 0);
        do_cycle(M1, 6, M1, 1, "R6 failed return ends at fetch T6");
    endtask

    task automatic t_jc_fail();
        set_instr(3'b101, 0, 0, 0, 0, 1);
        do_cycle(M1, 4, R1, 0, "R6 failed jump fetch");
        do_cycle(R1, 3, M1, 1, "R6 failed jump ends at R1 T3");
    endtask

    task automatic t_reset_mid();
        set_instr(3'b011, 0, 0, 0, 0, 0);
        do_cycle(M1, 4, R1, 0, "R9 pre-reset fetch");
        do_cycle(R1, 3, R2, 0, "R9 pre-reset R1");
        do_reset();
        set_instr(3'b111, 0, 0, 0, 0, 0);
        do_cycle(M1, 4, M1, 1, "R9 fetch after reset");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(cyc_flags == 5'b00001, "R1 R9 reset state M1", cyc_flags, 5'b00001);
        chk(next_instr == 1'b0, "R9 reset next_instr low", next_instr, 0);
        @(negedge clk);
        rst = 0;
        t_single_back_to_back();
        t_two_cycle();
        t_three_cycle();
        t_five_cycle();
        t_skip_r2();
        t_skip_w1();
        t_long_fetch();
        t_ret_fail();
        t_jc_fail();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule